// File: doc/BRIEF.md
# PS/2 Device-Side Serial Transceiver

This block sits at the device end of a two-wire PS/2 link. It generates every clock pulse on the link in both directions, whichever side is sending. It never drives either wire high. Its outputs are only pull-low enables. The wires are read back through separate sampled inputs, so the open-collector bus is modelled without tri-states. Every decision is taken on values that have passed through a two-flop synchronizer.

A higher layer hands bytes over on a valid/ready interface and receives host bytes on a byte-wide output with a one-cycle strobe and a parity-error flag. A sideband request lets that layer queue the acknowledge byte 0xFA after it has decoded a command. The block watches for two host actions. A clock wire held low is an inhibit, which aborts or defers a transmission. A data wire pulled low on an idle bus is a request to send, which starts a receive. The length of each clock half-period is a parameter. The default of 240 cycles gives 40 µs at 6 MHz.

Top module: `ps2_dev_xcvr`

## Requirements
- R1: A transmitted frame has 11 bits, each read on a falling edge of the clock wire. The bits are a 0 start bit, the eight data bits with bit 0 first, an odd-parity bit, and a stop bit of 1.
- R2: The device pulls the clock wire low for exactly HALF_CYC cycles per bit, and successive falling edges are 2*HALF_CYC cycles apart.
- R3: The data pull enable changes only while the clock wire is released and never while the device holds the clock low.
- R4: A byte is taken when tx_valid and tx_ready are both high. tx_ready then stays low until that byte's frame has completed, and then returns high.
- R5: While ack_req is high, tx_ready is low. With no byte pending, ack_req queues 0xFA in place of any byte offered on tx_data in the same cycle, and that offered byte is not sent.
- R6: If the host holds the clock wire low while the device has released it, host_inhibit rises and the device stops pulling the clock on the next cycle. The partial frame is dropped and the byte stays pending. Once the bus has been idle for a half-period, the byte is sent again as a complete frame.
- R7: On an idle bus, clock high with data low is a request to send. The device then generates 11 clocks and samples data at the end of each high phase. It pulls data low for a twelfth clock as the line acknowledge, and then presents the eight data bits on rx_data with rx_valid high for one cycle.
- R8: rx_perr is high, together with rx_valid, exactly when the received data bits plus the parity bit hold an even number of ones. rx_data is delivered in either case.
- R9: During reset both pull enables are low, tx_ready is high, rx_valid is low and host_inhibit is low.
- R10: When a host request to send and a pending byte are both present as the bus becomes idle, the device receives first and sends the pending byte afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | A byte can be taken this cycle |
| ack_req | input | 1 | Queue the acknowledge byte 0xFA |
| rx_data | output | 8 | Last byte received from the host |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_perr | output | 1 | Parity error on the byte being strobed |
| ps2_clk_in | input | 1 | Sampled level of the clock wire |
| ps2_dat_in | input | 1 | Sampled level of the data wire |
| ps2_clk_pull | output | 1 | Pull the clock wire low |
| ps2_dat_pull | output | 1 | Pull the data wire low |
| host_inhibit | output | 1 | The host is holding the clock wire low |

## Verification
The assertions assume the line inputs behave as a wired-AND of the device's own pull enables and a host model. Under that assumption, a clock wire the device is holding low reads low, and the host only ever adds further lows. They also assume that the higher layer offers bytes only through the handshake and that ack_req is a short request. The bench builds the wires as exactly that wired-AND. Its host pulls the clock only while the device has it released, and it changes data only on a falling clock edge during a request to send. Random bytes and random parity faults are drawn inside those rules, and directed cases add the inhibit abort, the acknowledge priority and the request-to-send that collides with a pending byte.

// File: rtl/ps2_pkg.sv
// Shared types and helpers for the PS/2 device transceiver.
// Assumes: frames are 11 bits with odd parity.
package ps2_pkg;
    typedef enum logic [1:0] {XS_IDLE, XS_SEND, XS_RECV} xfer_state_e;

    localparam int          FRAME_BITS = 11;
    localparam logic [7:0]  ACK_BYTE   = 8'hFA;

    // Parity bit that makes data plus parity hold an odd count of ones.
    function automatic logic odd_parity(input logic [7:0] d);
        return ~^d;
    endfunction
endpackage

// File: rtl/ps2_sync.sv
// Multi-bit, multi-stage flop synchronizer for asynchronous line levels.
// Assumes: each bit is independent; the reset value is the idle level.
module ps2_sync #(
    parameter int           W       = 2,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            // Shift the level one stage further towards the core clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n)      stg[i] <= RST_VAL;
                else if (i == 0) stg[i] <= d;
                else             stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ps2_txq.sv
// Single-entry holder for the byte waiting to go out on the wire.
// Assumes: done pulses once, when the frame carrying the held byte ends.
module ps2_txq
    import ps2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    input  logic       ack_req,
    input  logic       done,
    output logic       tx_ready,
    output logic       pend,
    output logic [7:0] held
);
    // Load the acknowledge byte or the offered byte; free the slot on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            held <= '0;
        end else if (done) begin
            pend <= 1'b0;
        end else if (!pend) begin
            if (ack_req) begin
                pend <= 1'b1;
                held <= ACK_BYTE;
            end else if (tx_valid) begin
                pend <= 1'b1;
                held <= tx_data;
            end
        end
    end

    assign tx_ready = !pend && !ack_req;
endmodule

// File: rtl/ps2_dev_xcvr.sv
// Device end of a PS/2 link: generates the clock, sends queued bytes,
// receives host bytes after a request to send, and honours host inhibit.
// Assumes: line inputs are the wired-AND of our pulls and the host's pulls.
module ps2_dev_xcvr
    import ps2_pkg::*;
#(
    parameter int HALF_CYC = 240
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    input  logic       ack_req,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_perr,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    output logic       ps2_clk_pull,
    output logic       ps2_dat_pull,
    output logic       host_inhibit
);
    localparam int CW       = $clog2(HALF_CYC + 1);
    localparam int SEND_END = FRAME_BITS - 1;
    localparam int RECV_END = FRAME_BITS;

    xfer_state_e      st;
    logic             ph_lo;
    logic [3:0]       bitn;
    logic [CW-1:0]    cnt;
    logic [FRAME_BITS-1:0] rx_sh;
    logic             clk_s, dat_s, own_s;
    logic             pend, send_done, half_end;
    logic [7:0]       held;
    logic [FRAME_BITS-1:0] frame;
    logic [3:0]       last_bit;

    ps2_sync #(.W(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ps2_clk_pull, ps2_clk_in, ps2_dat_in}),
        .q     ({own_s, clk_s, dat_s})
    );

    ps2_txq u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .ack_req  (ack_req),
        .done     (send_done),
        .tx_ready (tx_ready),
        .pend     (pend),
        .held     (held)
    );

    assign frame     = {1'b1, odd_parity(held), held, 1'b0};
    assign half_end  = (cnt == CW'(HALF_CYC - 1));
    assign last_bit  = (st == XS_SEND) ? 4'(SEND_END) : 4'(RECV_END);
    assign send_done = (st == XS_SEND) && ph_lo && half_end && (bitn == 4'(SEND_END));

    // Pull enables: clock low in the low phase, data per bit or the line acknowledge.
    always_comb begin
        ps2_clk_pull = (st != XS_IDLE) && ph_lo;
        ps2_dat_pull = 1'b0;
        if (st == XS_SEND && bitn < 4'(FRAME_BITS)) ps2_dat_pull = !frame[bitn];
        else if (st == XS_RECV)                     ps2_dat_pull = (bitn == 4'(RECV_END));
    end

    // Clock low while neither our current nor our recently synchronized pull explains it.
    assign host_inhibit = !clk_s && !own_s && !ps2_clk_pull;

    // Transfer sequencer: idle guard, half-period timing, bit stepping and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= XS_IDLE;
            ph_lo    <= 1'b0;
            bitn     <= '0;
            cnt      <= '0;
            rx_sh    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_perr  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_perr  <= 1'b0;
            if (st == XS_IDLE) begin
                ph_lo <= 1'b0;
                bitn  <= '0;
                if (clk_s && !own_s) begin
                    if (!half_end) begin
                        cnt <= cnt + 1'b1;
                    end else if (!dat_s) begin
                        st  <= XS_RECV;
                        cnt <= '0;
                    end else if (pend) begin
                        st  <= XS_SEND;
                        cnt <= '0;
                    end
                end else begin
                    cnt <= '0;
                end
            end else if (!ph_lo && host_inhibit) begin
                st  <= XS_IDLE;
                cnt <= '0;
            end else if (!half_end) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
                if (!ph_lo) begin
                    ph_lo <= 1'b1;
                    if (st == XS_RECV && bitn < 4'(FRAME_BITS)) rx_sh[bitn] <= dat_s;
                end else if (bitn == last_bit) begin
                    st    <= XS_IDLE;
                    ph_lo <= 1'b0;
                    if (st == XS_RECV) begin
                        rx_data  <= rx_sh[8:1];
                        rx_valid <= 1'b1;
                        rx_perr  <= ~^rx_sh[9:1];
                    end
                end else begin
                    bitn  <= bitn + 1'b1;
                    ph_lo <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/ps2_dev_xcvr_chk.sv
// Protocol checker for ps2_dev_xcvr, attached by bind.
// Assumes: the line inputs are a wired-AND with a well-behaved host.
module ps2_dev_xcvr_chk #(
    parameter int HALF_CYC = 240
) (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic rx_perr,
    input logic ps2_clk_pull,
    input logic ps2_dat_pull,
    input logic host_inhibit
);
    int lo_len;

    // Count how many cycles the clock pull has been held.
    always_ff @(posedge clk) begin
        if (!rst_n)            lo_len <= 0;
        else if (ps2_clk_pull) lo_len <= lo_len + 1;
        else                   lo_len <= 0;
    end

    a_r2_low_phase_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ps2_clk_pull) |-> (lo_len == HALF_CYC));

    a_r3_dat_steady_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ps2_clk_pull && $past(ps2_clk_pull)) |-> $stable(ps2_dat_pull));

    a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    a_r6_release_on_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        host_inhibit |=> !ps2_clk_pull);

    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r8_perr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_perr |-> rx_valid);
endmodule

bind ps2_dev_xcvr ps2_dev_xcvr_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .rx_valid     (rx_valid),
    .rx_perr      (rx_perr),
    .ps2_clk_pull (ps2_clk_pull),
    .ps2_dat_pull (ps2_dat_pull),
    .host_inhibit (host_inhibit)
);

// File: tb/sim_ps2_dev_xcvr.sv
module sim_ps2_dev_xcvr;
    localparam int HALF = 8;
    localparam int PER  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       ack_req = 1'b0;
    logic       tx_ready, rx_valid, rx_perr, dev_clk_pull, dev_dat_pull, host_inhibit;
    logic [7:0] rx_data;
    logic       host_clk_pull = 1'b0;
    logic       host_dat_pull = 1'b0;
    logic       clk_line, dat_line;

    int total = 0;
    int fails = 0;

    assign clk_line = !(dev_clk_pull | host_clk_pull);
    assign dat_line = !(dev_dat_pull | host_dat_pull);

    always #10 clk = ~clk;

    ps2_dev_xcvr #(.HALF_CYC(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .ack_req(ack_req), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_perr(rx_perr), .ps2_clk_in(clk_line),
        .ps2_dat_in(dat_line), .ps2_clk_pull(dev_clk_pull),
        .ps2_dat_pull(dev_dat_pull), .host_inhibit(host_inhibit)
    );

    function automatic logic exp_par(input logic [7:0] b);
        int n = 0;
        for (int i = 0; i < 8; i++) n += b[i];
        return (n % 2 == 0);
    endfunction

    function automatic logic [10:0] exp_frame(input logic [7:0] b);
        return {1'b1, exp_par(b), b, 1'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic offer(input logic [7:0] b);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = b;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R4 ready low after take", tx_ready, 0);
    endtask

    // Read one device frame on falling clock edges and measure its timing.
    task automatic capture(input logic [7:0] b);
        logic [10:0] f;
        time t0, t1, t2;
        for (int k = 0; k < 11; k++) begin
            @(negedge clk_line);
            if (k == 0) t0 = $time;
            if (k == 1) t2 = $time;
            #1 f[k] = dat_line;
            if (k == 0) begin
                @(posedge clk_line);
                t1 = $time;
            end
        end
        chk(f == exp_frame(b), "R1 frame bits", f, exp_frame(b));
        chk((t1 - t0) == HALF * PER, "R2 low width", int'(t1 - t0), HALF * PER);
        chk((t2 - t0) == 2 * HALF * PER, "R2 bit period", int'(t2 - t0), 2 * HALF * PER);
        repeat (HALF + 3) @(negedge clk);
        chk(tx_ready == 1'b1, "R4 ready back after frame", tx_ready, 1);
    endtask

    // Host request to send; pre means data is already held low.
    task automatic host_send(input logic [7:0] b, input bit bad, input bit pre);
        logic [10:0] f;
        bit got = 0;
        logic [7:0] d = '0;
        logic p = 1'b0;
        f = {1'b1, exp_par(b) ^ bad, b, 1'b0};
        if (!pre) begin
            @(negedge clk);
            host_dat_pull = 1'b1;
        end
        for (int k = 1; k < 11; k++) begin
            @(negedge clk_line);
            #2 host_dat_pull = !f[k];
        end
        @(negedge clk_line);
        @(negedge clk_line);
        #5 chk(dat_line == 1'b0, "R7 line acknowledge", dat_line, 0);
        for (int i = 0; i < 4 * HALF && !got; i++) begin
            @(negedge clk);
            if (rx_valid) begin
                got = 1;
                d = rx_data;
                p = rx_perr;
            end
        end
        chk(got, "R7 rx_valid strobe", got, 1);
        chk(d == b, "R7 rx_data", d, b);
        chk(p == bad, "R8 parity flag", p, bad);
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] b;
        bit quiet;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!dev_clk_pull && !dev_dat_pull, "R9 pulls released in reset", {dev_clk_pull, dev_dat_pull}, 0);
        chk(tx_ready == 1'b1, "R9 ready in reset", tx_ready, 1);
        chk(rx_valid == 1'b0, "R9 rx_valid in reset", rx_valid, 0);
        chk(host_inhibit == 1'b0, "R9 inhibit in reset", host_inhibit, 0);
        rst_n = 1'b1;

        // Directed corners, then random bytes out.
        foreach (b[i]) ;
        offer(8'h00); capture(8'h00);
        offer(8'hFF); capture(8'hFF);
        for (int n = 0; n < 6; n++) begin
            b = 8'($urandom);
            offer(b);
            capture(b);
        end

        // R5: acknowledge request wins over a same-cycle offer.
        @(negedge clk);
        ack_req = 1'b1; tx_valid = 1'b1; tx_data = 8'h33;
        #1 chk(tx_ready == 1'b0, "R5 ready low under ack_req", tx_ready, 0);
        @(negedge clk);
        ack_req = 1'b0; tx_valid = 1'b0;
        capture(8'hFA);
        quiet = 1;
        for (int i = 0; i < 4 * HALF; i++) begin
            @(negedge clk);
            if (!clk_line) quiet = 0;
        end
        chk(quiet, "R5 offered byte dropped", quiet, 1);

        // R6: inhibit mid-frame, then full retransmission.
        offer(8'hA5);
        repeat (3) @(posedge clk_line);
        @(negedge clk);
        host_clk_pull = 1'b1;
        repeat (4) @(negedge clk);
        chk(host_inhibit == 1'b1, "R6 inhibit seen", host_inhibit, 1);
        chk(tx_ready == 1'b0, "R6 byte kept pending", tx_ready, 0);
        quiet = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (dev_clk_pull || dev_dat_pull) quiet = 0;
        end
        chk(quiet, "R6 lines released while inhibited", quiet, 1);
        host_clk_pull = 1'b0;
        capture(8'hA5);

        // R7/R8: host bytes in, some with bad parity.
        repeat (2 * HALF) @(negedge clk);
        host_send(8'h00, 0, 0);
        host_send(8'hC3, 1, 0);
        for (int n = 0; n < 5; n++) begin
            host_send(8'($urandom), 1'($urandom), 0);
        end

        // R10: request to send collides with a pending byte.
        @(negedge clk);
        host_clk_pull = 1'b1;
        offer(8'h5C);
        @(negedge clk);
        host_clk_pull = 1'b0;
        host_dat_pull = 1'b1;
        host_send(8'h96, 0, 1);
        capture(8'h5C);
        chk(1, "R10 receive before pending send", 1, 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule